// File: doc/BRIEF.md
# Grouped-Access Register File

This block is the register storage of a compute cluster. It holds thirty-two 32-bit registers and has two read ports and one write port. All three ports work in the same cycle, and every register can be reached from every port. Each access moves one register, an aligned pair of registers, or an aligned group of four. Because of this the data buses are 128 bits wide. A 2-bit size code and a 5-bit base register number describe each access.

A request whose base register number does not match its group size is rejected, and so is a request with the reserved size code. A rejected request raises an error strobe for its port, changes no register, and reads as zero. Reads are combinational. A read that overlaps a write in the same cycle sees the incoming write data on the overlapping words. A write takes effect at the next rising clock edge.

Top module: `grouped_regfile`

## Requirements
- R1: After reset every register reads as zero, for every size and both read ports.
- R2: With size code 00, a port reads or writes the single register at any base number 0..31. That register sits in bits [31:0] of the bus.
- R3: With size code 01 and an even base number b, a port moves registers b and b+1. Register b sits in bits [31:0] and register b+1 in bits [63:32].
- R4: With size code 10 and a base number b that is a multiple of four, a port moves registers b..b+3. Register b+k sits in bits [32k+31:32k].
- R5: A pair request at an odd base number, or a quad request at a base number that is not a multiple of four, raises that port's error strobe in the same cycle. Such a write changes no register, and such a read returns all zeros.
- R6: Size code 11 is reserved. It raises the port's error strobe, blocks the write, and reads as all zeros.
- R7: In a write cycle with no error, a read of a register that the write covers returns the new write data for that word. The other words of the same read return the stored values.
- R8: The two read ports are independent. In the same cycle they return the values for their own size and base number.
- R9: Bus bits above the words of the requested group read as zero.
- R10: While the write enable is low, no register changes and the write error strobe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rstN | input | 1 | Active-low synchronous reset; clears all registers |
| wrEn | input | 1 | Write request |
| wrSize | input | 2 | Write group size code (00 word, 01 pair, 10 quad, 11 reserved) |
| wrIdx | input | 5 | Write base register number |
| wrData | input | 128 | Write data; lowest register in bits [31:0] |
| wrErr | output | 1 | Write request rejected (misaligned or reserved size) |
| rdSizeA | input | 2 | Read port A group size code |
| rdIdxA | input | 5 | Read port A base register number |
| rdDataA | output | 128 | Read port A data |
| rdErrA | output | 1 | Read port A request rejected |
| rdSizeB | input | 2 | Read port B group size code |
| rdIdxB | input | 5 | Read port B base register number |
| rdDataB | output | 128 | Read port B data |
| rdErrB | output | 1 | Read port B request rejected |

## Verification
The assertions check four things on every cycle. A rejected read drives a zero bus. A single-word read leaves the upper bits clear. An enabled write lands in its register at the next edge. A rejected or idle write leaves the whole file unchanged. Some behaviour only the bench scenarios can show. These are the exact placement of words across pairs and quads, the split between bypassed and stored words when a read partly overlaps a write, and the two read ports returning different groups in the same cycle. To show these, the bench sweeps every size code against every base number on the write port while both read ports look at related groups. It compares each bus against a model of the file kept in the bench.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int IdxW     = 5;
  localparam int NumRegs  = 1 << IdxW;
  localparam int MaxLanes = 4;

  typedef enum logic [1:0] {
    SzWord = 2'b00,
    SzPair = 2'b01,
    SzQuad = 2'b10,
    SzRsvd = 2'b11
  } grpSize_e;

  // Decoded request for one port, passed from control to datapath.
  typedef struct packed {
    logic                err;
    logic [MaxLanes-1:0] laneEn;
    logic [IdxW-1:0]     base;
  } portCtl_t;

  function automatic portCtl_t decodeReq(input logic en, input logic [1:0] size,
                                         input logic [IdxW-1:0] idx);
    portCtl_t c;
    c.base   = idx;
    c.laneEn = '0;
    c.err    = 1'b0;
    if (en) begin
      case (grpSize_e'(size))
        SzWord: c.laneEn = 4'b0001;
        SzPair: if (idx[0] == 1'b0) c.laneEn = 4'b0011; else c.err = 1'b1;
        SzQuad: if (idx[1:0] == 2'b00) c.laneEn = 4'b1111; else c.err = 1'b1;
        default: c.err = 1'b1;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/rf_ctl.sv
module rf_ctl
  import rf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrSize,
  input  logic [IdxW-1:0] wrIdx,
  input  logic [1:0]      rdSizeA,
  input  logic [IdxW-1:0] rdIdxA,
  input  logic [1:0]      rdSizeB,
  input  logic [IdxW-1:0] rdIdxB,
  output portCtl_t        wrCtl,
  output portCtl_t        rdCtlA,
  output portCtl_t        rdCtlB
);
  always_comb begin
    wrCtl  = decodeReq(wrEn, wrSize, wrIdx);
    rdCtlA = decodeReq(1'b1, rdSizeA, rdIdxA);
    rdCtlB = decodeReq(1'b1, rdSizeB, rdIdxB);
  end

  // R6
  rsvd_wr_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == 2'b11) |-> wrCtl.err);

  // R10
  idle_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (!wrCtl.err && wrCtl.laneEn == '0));
endmodule

// File: rtl/rf_data.sv
module rf_data
  import rf_pkg::*;
#(
  parameter int WordW = 32,
  localparam int BusW = WordW * MaxLanes
) (
  input  logic            clk,
  input  logic            rstN,
  input  portCtl_t        wrCtl,
  input  logic [BusW-1:0] wrData,
  input  portCtl_t        rdCtlA,
  input  portCtl_t        rdCtlB,
  output logic [BusW-1:0] rdDataA,
  output logic [BusW-1:0] rdDataB
);
  logic [NumRegs-1:0][WordW-1:0] regs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs <= '0;
    end else begin
      for (int l = 0; l < MaxLanes; l++) begin
        if (wrCtl.laneEn[l]) regs[wrCtl.base + IdxW'(l)] <= wrData[l*WordW +: WordW];
      end
    end
  end

  function automatic logic [BusW-1:0] readGroup(input portCtl_t rc, input portCtl_t wc,
      input logic [NumRegs-1:0][WordW-1:0] file, input logic [BusW-1:0] wd);
    logic [BusW-1:0] bus;
    logic [IdxW-1:0] r;
    bus = '0;
    for (int l = 0; l < MaxLanes; l++) begin
      if (rc.laneEn[l]) begin
        r = rc.base + IdxW'(l);
        bus[l*WordW +: WordW] = file[r];
        for (int k = 0; k < MaxLanes; k++) begin
          if (wc.laneEn[k] && (wc.base + IdxW'(k)) == r) bus[l*WordW +: WordW] = wd[k*WordW +: WordW];
        end
      end
    end
    return bus;
  endfunction

  generate
    for (genvar p = 0; p < 2; p++) begin : g_rdPort
      if (p == 0) begin : g_a
        always_comb rdDataA = readGroup(rdCtlA, wrCtl, regs, wrData);
      end else begin : g_b
        always_comb rdDataB = readGroup(rdCtlB, wrCtl, regs, wrData);
      end
    end
  endgenerate

  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rstN) |-> regs == '0);

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl.laneEn[0] |=> regs[$past(wrCtl.base)] == $past(wrData[WordW-1:0]));

  // R5
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl.laneEn == '0) |=> $stable(regs));
endmodule

// File: rtl/grouped_regfile.sv
module grouped_regfile
  import rf_pkg::*;
#(
  parameter int WordW = 32,
  localparam int BusW = WordW * MaxLanes
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrSize,
  input  logic [IdxW-1:0] wrIdx,
  input  logic [BusW-1:0] wrData,
  output logic            wrErr,
  input  logic [1:0]      rdSizeA,
  input  logic [IdxW-1:0] rdIdxA,
  output logic [BusW-1:0] rdDataA,
  output logic            rdErrA,
  input  logic [1:0]      rdSizeB,
  input  logic [IdxW-1:0] rdIdxB,
  output logic [BusW-1:0] rdDataB,
  output logic            rdErrB
);
  portCtl_t wrCtl, rdCtlA, rdCtlB;

  rf_ctl i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSize(wrSize), .wrIdx(wrIdx),
    .rdSizeA(rdSizeA), .rdIdxA(rdIdxA), .rdSizeB(rdSizeB), .rdIdxB(rdIdxB),
    .wrCtl(wrCtl), .rdCtlA(rdCtlA), .rdCtlB(rdCtlB)
  );

  rf_data #(.WordW(WordW)) i_data (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .wrData(wrData),
    .rdCtlA(rdCtlA), .rdCtlB(rdCtlB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  assign wrErr  = wrCtl.err;
  assign rdErrA = rdCtlA.err;
  assign rdErrB = rdCtlB.err;

  // R5
  rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdErrA |-> rdDataA == '0) and (rdErrB |-> rdDataB == '0));

  // R9
  word_upper_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeA == 2'b00) |-> rdDataA[BusW-1:WordW] == '0);
endmodule

// File: tb/test_grouped_regfile.sv
module test_grouped_regfile;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrSize = '0;
  logic [4:0]   wrIdx = '0;
  logic [127:0] wrData = '0;
  logic         wrErr;
  logic [1:0]   rdSizeA = '0, rdSizeB = '0;
  logic [4:0]   rdIdxA = '0, rdIdxB = '0;
  logic [127:0] rdDataA, rdDataB;
  logic         rdErrA, rdErrB;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [32];

  grouped_regfile i_grouped_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSize(wrSize), .wrIdx(wrIdx),
    .wrData(wrData), .wrErr(wrErr), .rdSizeA(rdSizeA), .rdIdxA(rdIdxA),
    .rdDataA(rdDataA), .rdErrA(rdErrA), .rdSizeB(rdSizeB), .rdIdxB(rdIdxB),
    .rdDataB(rdDataB), .rdErrB(rdErrB)
  );

  always #2 clk = ~clk;

  function automatic bit reqOk(input int s, input int i);
    if (s == 0) return 1'b1;
    if (s == 1) return (i % 2) == 0;
    if (s == 2) return (i % 4) == 0;
    return 1'b0;
  endfunction

  function automatic logic [127:0] pattern(input int s, input int i);
    logic [127:0] v;
    for (int k = 0; k < 4; k++)
      v[k*32 +: 32] = 32'h9E3779B9 * 32'(s * 32 + i + 7) + 32'h01234567 * 32'(k + 1);
    return v;
  endfunction

  // Expected read bus, with same-cycle bypass from an accepted write.
  function automatic logic [127:0] expRead(input int rs, input int ri, input bit we,
                                           input int ws, input int wi, input logic [127:0] wd);
    logic [127:0] v = '0;
    int wn;
    if (!reqOk(rs, ri)) return v;
    wn = (we && reqOk(ws, wi)) ? (1 << ws) : 0;
    for (int l = 0; l < (1 << rs); l++) begin
      int r = ri + l;
      if (r >= wi && r < wi + wn) v[l*32 +: 32] = wd[(r - wi)*32 +: 32];
      else v[l*32 +: 32] = model[r];
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readAll(input string req);
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 32; i += (1 << s)) begin
        @(negedge clk);
        rdSizeA = 2'(s); rdIdxA = 5'(i);
        rdSizeB = 2'(s); rdIdxB = 5'(31 - i - ((1 << s) - 1));
        #1;
        check(req, rdDataA, expRead(s, i, 0, 0, 0, '0));
        check({req, " R8"}, rdDataB, expRead(s, 31 - i - ((1 << s) - 1), 0, 0, 0, '0));
      end
  endtask

  initial begin
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    readAll("R1");

    // Sweep every size/base on the write port, reading overlapping groups alongside.
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 32; i++) begin
        logic [127:0] d = pattern(s, i);
        int ra = i & ~1;
        int rb = i & ~3;
        @(negedge clk);
        wrEn = 1'b1; wrSize = 2'(s); wrIdx = 5'(i); wrData = d;
        rdSizeA = 2'b01; rdIdxA = 5'(ra);
        rdSizeB = 2'b10; rdIdxB = 5'(rb);
        #1;
        check(reqOk(s, i) ? "R2 R3 R4 wrErr" : (s == 3 ? "R6 wrErr" : "R5 wrErr"),
              {127'd0, wrErr}, {127'd0, !reqOk(s, i)});
        check("R7 R9 portA", rdDataA, expRead(1, ra, 1, s, i, d));
        check("R7 R4 portB", rdDataB, expRead(2, rb, 1, s, i, d));
        if (reqOk(s, i)) for (int l = 0; l < (1 << s); l++) model[i + l] = d[l*32 +: 32];
      end
    @(negedge clk) wrEn = 1'b0;
    readAll("R2 R3 R4 R5 R6");

    // Rejected reads on each port.
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rdSizeA = 2'b11; rdIdxA = 5'(i);
      rdSizeB = (i % 4 != 0) ? 2'b10 : 2'b01; rdIdxB = 5'(i | 1);
      #1;
      check("R6 rdErrA", {rdErrA, rdDataA}, {1'b1, 128'd0});
      check("R5 rdErrB", {rdErrB, rdDataB}, {1'b1, 128'd0});
    end

    // Write enable low: data presented but nothing changes.
    @(negedge clk);
    wrEn = 1'b0; wrSize = 2'b10; wrIdx = 5'd8; wrData = ~128'd0;
    rdSizeA = 2'b10; rdIdxA = 5'd8;
    #1;
    check("R10 wrErr", {127'd0, wrErr}, 128'd0);
    check("R10 no bypass", rdDataA, expRead(2, 8, 0, 0, 0, '0));
    @(negedge clk); #1;
    check("R10 no write", rdDataA, expRead(2, 8, 0, 0, 0, '0));
    wrSize = 2'b11;
    #1;
    check("R10 rsvd idle", {127'd0, wrErr}, 128'd0);

    // Reset clears everything again.
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    for (int r = 0; r < 32; r++) model[r] = '0;
    readAll("R1 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule